// File: doc/BRIEF.md
# Dual-Channel Phase Detector with Lock Indication and Status Select

This block holds two independent digital phase-frequency comparators, one per synthesizer channel (A and B), running in a common clock domain. Each comparator watches two single-cycle strobes: the divided reference and the divided feedback. From them it produces pump-up and pump-down enables for an external charge pump, together with a three-state control. A lock monitor on each channel measures the width of every correction pulse. It declares lock after a run of consecutive narrow comparisons.

A four-bit select chooses which internal signal drives a single status pin. The choices are either channel's lock indication, a joint indication that needs both channels locked, or either channel's divider strobes passed straight through. Each channel can be stopped by a power-down or a counter-reset input. Stopping a channel floats its pump controls, clears its pump enables and drops its lock state.

All pins are plain control and status signals. There is no streamed data path, so there is no valid/ready handshake and no back-pressure.

Top module: `dual_pfd_lockmux`

## Requirements
- R1: When an enabled channel is idle and its reference strobe arrives k cycles (k >= 1) before its feedback strobe, `cp_up` of that channel is high for exactly k cycles, starting the cycle after the reference strobe, and `cp_dn` stays low.
- R2: When the feedback strobe leads the reference strobe by k cycles (k >= 1), `cp_dn` is high for exactly k cycles and `cp_up` stays low.
- R3: Reference and feedback strobes in the same cycle on an idle channel produce no pump pulse. They count as a comparison of width 0.
- R4: A channel is stopped when its `pwr_down` or `cnt_reset` bit is 1. While stopped, its `cp_hiz` is 1, its `cp_up` and `cp_dn` stay 0 from the next cycle onward, and its lock state is cleared. While running, its `cp_hiz` is 0.
- R5: A channel becomes locked once LOCK_RUN consecutive comparisons (default 4) have had a pump-pulse width of at most WIDTH_MAX cycles (default 2).
- R6: A comparison wider than WIDTH_MAX clears the lock and restarts the run count. The lock is cleared as soon as the pulse exceeds WIDTH_MAX.
- R7: A channel's lock indication is high while locked, except that it goes low in every cycle in which that channel's `cp_up` or `cp_dn` is high.
- R8: The joint indication (select code 4) is high only when both channels' lock indications are high.
- R9: `mux_sel` codes: 1 = A lock, 2 = A reference strobe, 3 = A feedback strobe, 4 = joint lock, 5 = B reference strobe, 6 = B feedback strobe, 7 = B lock. Code 0 and codes 8 to 15 drive `mux_out` low. The strobe codes pass the input through in the same cycle, whether the channel is running or stopped.
- R10: While `rst_n` is low, `cp_up`, `cp_dn` and both lock states are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 2 | Divided reference strobe per channel (bit 0 = A, bit 1 = B) |
| fb_pulse | input | 2 | Divided feedback strobe per channel |
| pwr_down | input | 2 | Power-down per channel |
| cnt_reset | input | 2 | Counter-reset per channel |
| mux_sel | input | 4 | Status-pin source select |
| cp_up | output | 2 | Pump-up enable per channel |
| cp_dn | output | 2 | Pump-down enable per channel |
| cp_hiz | output | 2 | Pump three-state control per channel (1 = float) |
| mux_out | output | 1 | Selected status signal |

## Verification
The assertions assume that each strobe is a single-cycle pulse. They also assume that a new reference or feedback strobe never lands in the same cycle that an ongoing correction pulse ends, because the detector would absorb such a strobe. The stimulus therefore drives every comparison as one leading strobe and one lagging strobe, then leaves at least four idle cycles before the next. Stop inputs and select changes are applied only on idle channels.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;
  typedef enum logic [3:0] {
    SEL_OFF       = 4'd0,
    SEL_A_LOCK    = 4'd1,
    SEL_A_REF     = 4'd2,
    SEL_A_FB      = 4'd3,
    SEL_JOINT     = 4'd4,
    SEL_B_REF     = 4'd5,
    SEL_B_FB      = 4'd6,
    SEL_B_LOCK    = 4'd7
  } mux_code_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ref_p,
  input  logic fb_p,
  output logic up,
  output logic dn,
  output logic done
);
  logic up_q, dn_q, done_q;
  logic up_set, dn_set, both;

  always_comb begin
    up_set = up_q | ref_p;
    dn_set = dn_q | fb_p;
    both   = up_set & dn_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      up_q   <= up_set & ~both;
      dn_q   <= dn_set & ~both;
      done_q <= both;
    end
  end

  assign up   = up_q;
  assign dn   = dn_q;
  assign done = done_q;

  assert_ref_starts_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ref_p && !fb_p && !up_q && !dn_q) |=> up_q);

  assert_fb_starts_dn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fb_p && !ref_p && !up_q && !dn_q) |=> dn_q);

  assert_stopped_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!up_q && !dn_q));
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
  parameter int unsigned WIDTH_MAX = 2,
  parameter int unsigned LOCK_RUN  = 4,
  localparam int unsigned WW = $clog2(WIDTH_MAX + 2),
  localparam int unsigned RW = $clog2(LOCK_RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic act,
  input  logic done,
  output logic locked,
  output logic ld
);
  localparam logic [WW-1:0] W_LIM = WW'(WIDTH_MAX);
  localparam logic [RW-1:0] R_LIM = RW'(LOCK_RUN);

  logic [WW-1:0] wcnt;
  logic [RW-1:0] good;
  logic [RW-1:0] good_nxt;
  logic          locked_q;

  always_comb good_nxt = (good == R_LIM) ? good : good + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      wcnt     <= '0;
      good     <= '0;
      locked_q <= 1'b0;
    end else if (done) begin
      wcnt <= '0;
      if (wcnt <= W_LIM) begin
        good     <= good_nxt;
        locked_q <= locked_q | (good_nxt == R_LIM);
      end else begin
        good     <= '0;
        locked_q <= 1'b0;
      end
    end else if (act) begin
      wcnt <= (wcnt > W_LIM) ? wcnt : wcnt + 1'b1;
      if (wcnt >= W_LIM) begin
        good     <= '0;
        locked_q <= 1'b0;
      end
    end
  end

  assign locked = locked_q;
  assign ld     = en & locked_q & ~act;

  assert_lock_after_cmp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(done));

  assert_wide_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act && !done && wcnt >= W_LIM) |=> !locked_q);

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> !locked_q);
endmodule

// File: rtl/status_mux.sv
module status_mux
  import pfd_lock_pkg::*;
(
  input  logic [3:0] sel,
  input  logic [1:0] ld,
  input  logic [1:0] ref_p,
  input  logic [1:0] fb_p,
  output logic       out
);
  always_comb begin
    unique case (sel)
      SEL_A_LOCK: out = ld[0];
      SEL_A_REF:  out = ref_p[0];
      SEL_A_FB:   out = fb_p[0];
      SEL_JOINT:  out = ld[0] & ld[1];
      SEL_B_REF:  out = ref_p[1];
      SEL_B_FB:   out = fb_p[1];
      SEL_B_LOCK: out = ld[1];
      default:    out = 1'b0;
    endcase
  end
endmodule

// File: rtl/dual_pfd_lockmux.sv
module dual_pfd_lockmux
  import pfd_lock_pkg::*;
#(
  parameter int unsigned WIDTH_MAX = 2,
  parameter int unsigned LOCK_RUN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_pulse,
  input  logic [1:0] fb_pulse,
  input  logic [1:0] pwr_down,
  input  logic [1:0] cnt_reset,
  input  logic [3:0] mux_sel,
  output logic [1:0] cp_up,
  output logic [1:0] cp_dn,
  output logic [1:0] cp_hiz,
  output logic       mux_out
);
  logic [NUM_CH-1:0] ch_en, ch_done, ch_lock, ch_ld;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_en[c]  = ~pwr_down[c] & ~cnt_reset[c];
    assign cp_hiz[c] = ~ch_en[c];

    pfd_core u_pfd (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ch_en[c]),
      .ref_p (ref_pulse[c]),
      .fb_p  (fb_pulse[c]),
      .up    (cp_up[c]),
      .dn    (cp_dn[c]),
      .done  (ch_done[c])
    );

    lock_monitor #(
      .WIDTH_MAX (WIDTH_MAX),
      .LOCK_RUN  (LOCK_RUN)
    ) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ch_en[c]),
      .act    (cp_up[c] | cp_dn[c]),
      .done   (ch_done[c]),
      .locked (ch_lock[c]),
      .ld     (ch_ld[c])
    );
  end

  status_mux u_mux (
    .sel   (mux_sel),
    .ld    (ch_ld),
    .ref_p (ref_pulse),
    .fb_p  (fb_pulse),
    .out   (mux_out)
  );

  assert_lock_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel == 4'd1 && (cp_up[0] || cp_dn[0])) |-> !mux_out);

  assert_joint_needs_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel == 4'd4 && mux_out) |-> (ch_lock[0] && ch_lock[1]));

  assert_unused_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel == 4'd0 || mux_sel >= 4'd8) |-> !mux_out);

  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_n |=> (cp_up == 2'b00 && cp_dn == 2'b00));
endmodule

// File: tb/dual_pfd_lockmux_bench.sv
module dual_pfd_lockmux_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic [1:0] ref_pulse, fb_pulse, pwr_down, cnt_reset;
  logic [3:0] mux_sel;
  logic [1:0] cp_up, cp_dn, cp_hiz;
  logic       mux_out;

  dual_pfd_lockmux u_dual_pfd_lockmux (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .pwr_down(pwr_down), .cnt_reset(cnt_reset), .mux_sel(mux_sel),
    .cp_up(cp_up), .cp_dn(cp_dn), .cp_hiz(cp_hiz), .mux_out(mux_out)
  );

  typedef struct { int ch; bit is_up; int width; } exp_t;
  exp_t sbq[$];
  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;
  int  run_up[2];
  int  run_dn[2];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pop_cmp(int ch, bit is_up, int width);
    exp_t e;
    checks++;
    if (sbq.size() == 0) begin
      fails++;
      $display("FAIL %s unexpected pulse ch%0d actual=%0d expected=0",
               is_up ? "R1" : "R2", ch, width);
    end else begin
      e = sbq.pop_front();
      if (e.ch != ch || e.is_up != is_up || e.width != width) begin
        fails++;
        $display("FAIL %s pulse ch%0d/%0d actual=%0d expected=%0d (ch%0d/%0d)",
                 e.is_up ? "R1" : "R2", ch, is_up, width, e.width, e.ch, e.is_up);
      end
    end
  endtask

  // monitor: measures each pump pulse and compares it with the scoreboard
  initial begin
    run_up = '{0, 0};
    run_dn = '{0, 0};
    forever begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        if (cp_up[c]) run_up[c]++;
        else if (run_up[c] > 0) begin pop_cmp(c, 1'b1, run_up[c]); run_up[c] = 0; end
        if (cp_dn[c]) run_dn[c]++;
        else if (run_dn[c] > 0) begin pop_cmp(c, 1'b0, run_dn[c]); run_dn[c] = 0; end
      end
    end
  end

  // driver: one comparison; lead 0 = coincident strobes
  task automatic cmp(int ch, bit ref_first, int lead, bit probe, bit quiet);
    @(negedge clk);
    if (lead == 0) begin
      ref_pulse[ch] = 1'b1;
      fb_pulse[ch]  = 1'b1;
      @(negedge clk);
      ref_pulse[ch] = 1'b0;
      fb_pulse[ch]  = 1'b0;
      check("R3 no pulse on coincident strobes", int'(cp_up[ch] | cp_dn[ch]), 0);
    end else begin
      if (!quiet) sbq.push_back('{ch, ref_first, lead});
      if (ref_first) ref_pulse[ch] = 1'b1; else fb_pulse[ch] = 1'b1;
      @(negedge clk);
      ref_pulse[ch] = 1'b0;
      fb_pulse[ch]  = 1'b0;
      if (probe) check("R7 lock low during pump pulse", int'(mux_out), 0);
      if (quiet) check("R4 stopped channel no pump", int'(cp_up[ch] | cp_dn[ch]), 0);
      for (int i = 1; i < lead; i++) @(negedge clk);
      if (ref_first) fb_pulse[ch] = 1'b1; else ref_pulse[ch] = 1'b1;
      @(negedge clk);
      ref_pulse[ch] = 1'b0;
      fb_pulse[ch]  = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic see(string req, logic [3:0] sel, int exp);
    @(negedge clk);
    mux_sel = sel;
    #1;
    check(req, int'(mux_out), exp);
  endtask

  initial begin
    rst_n = 1'b0;
    ref_pulse = '0; fb_pulse = '0; pwr_down = '0; cnt_reset = '0;
    mux_sel = 4'd1;
    repeat (3) @(negedge clk);
    check("R10 reset up", int'(cp_up), 0);
    check("R10 reset dn", int'(cp_dn), 0);
    check("R10 reset lock", int'(mux_out), 0);
    check("R4 running hiz low", int'(cp_hiz), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 3; i++) cmp(0, 1'b1, 1, 1'b0, 1'b0);
    see("R5 not locked after 3", 4'd1, 0);
    cmp(0, 1'b1, 1, 1'b0, 1'b0);
    see("R5 locked after 4", 4'd1, 1);
    cmp(0, 1'b1, 2, 1'b1, 1'b0);
    see("R5 width at limit keeps lock", 4'd1, 1);
    cmp(0, 1'b0, 0, 1'b0, 1'b0);
    see("R3 coincident keeps lock", 4'd1, 1);

    cmp(0, 1'b1, 4, 1'b0, 1'b0);
    see("R6 wide pulse drops lock", 4'd1, 0);
    cmp(0, 1'b1, 1, 1'b0, 1'b0);
    see("R6 run restarted", 4'd1, 0);
    for (int i = 0; i < 3; i++) cmp(0, 1'b1, 1, 1'b0, 1'b0);
    see("R5 relocked", 4'd1, 1);

    see("R8 joint low with B unlocked", 4'd4, 0);
    for (int i = 0; i < 4; i++) cmp(1, 1'b0, 2, 1'b0, 1'b0);
    see("R9 B lock code 7", 4'd7, 1);
    see("R8 joint high", 4'd4, 1);
    see("R9 code 0 low", 4'd0, 0);
    see("R9 code 9 low", 4'd9, 0);
    see("R9 code 15 low", 4'd15, 0);

    @(negedge clk);
    pwr_down[0] = 1'b1;
    cnt_reset[1] = 1'b1;
    #1;
    check("R4 power-down hiz", int'(cp_hiz[0]), 1);
    check("R4 counter-reset hiz", int'(cp_hiz[1]), 1);
    see("R4 A lock cleared", 4'd1, 0);
    see("R4 B lock cleared", 4'd7, 0);
    mux_sel = 4'd1;
    cmp(0, 1'b1, 2, 1'b0, 1'b1);

    see("R9 A ref idle", 4'd2, 0);
    ref_pulse[0] = 1'b1; #1;
    check("R9 A ref passthrough", int'(mux_out), 1);
    ref_pulse[0] = 1'b0;
    see("R9 B fb idle", 4'd6, 0);
    fb_pulse[1] = 1'b1; #1;
    check("R9 B fb passthrough", int'(mux_out), 1);
    fb_pulse[1] = 1'b0;

    @(negedge clk);
    pwr_down = '0;
    cnt_reset = '0;
    #1;
    check("R4 restart hiz low", int'(cp_hiz), 0);
    repeat (4) @(negedge clk);
    check("R1 scoreboard drained", sbq.size(), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule